// File: doc/BRIEF.md
# Byte-wide EEPROM page-write sequencer

This block models the write-control logic of a byte-wide parallel EEPROM with 15 address lines and 8-bit words. It decodes the active-low chip select, output enable and write strobe into read, write, standby and inhibit modes. Each accepted write strobe places one byte into a 128-byte page buffer. A byte-load timer decides when the gathered bytes are committed. A self-timed program cycle then writes them into a storage array, and during that cycle reads return end-of-write status instead of data.

The host loads a page by issuing write strobes back to back. Each gap between strobes must stay shorter than the load window. When the strobes stop, the page is programmed in one cycle. The host polls the bus until the status pattern gives way to the stored data. All strobes are sampled on the system clock. Every time constant (glitch width, load window, program time, power-up delays) is a parameter counted in clock cycles.

The storage array holds 2^ROW_W pages. The 8-bit row number is folded into a page slot by XOR-ing its ROW_W-bit groups, and ROW_W must divide ADDR_W-PAGE_W.

Top module: `pee_page_writer`

## Requirements
- R1: `dout_en` is high only while chip select is low, output enable is low and write strobe is high, and only once PUR_CYC cycles have passed since reset. In standby, write and inhibit modes it is low.
- R2: A write strobe exists only while chip select is low, output enable is high and write strobe is low. Address and data are taken from the last sampled cycle of that strobe. With output enable low, a low write strobe writes nothing.
- R3: A strobe shorter than GLITCH_CYC sampled cycles is ignored. A strobe of exactly GLITCH_CYC cycles is accepted.
- R4: Address bits [6:0] pick the byte inside the page buffer. A second write to the same offset before commit replaces the earlier byte.
- R5: The end of each accepted strobe restarts a LOAD_CYC-cycle load timer, and the start of a strobe stops it. While the timer is stopped no commit takes place. Once the timer expires, the gathered bytes are committed, and a gap longer than LOAD_CYC splits writes into separate commits.
- R6: The page slot written is the one selected by address bits [14:7] of the last accepted byte. Only offsets loaded since the previous commit change, and the other bytes of the slot keep their values.
- R7: The program cycle lasts PROG_CYC cycles. Write strobes during it are ignored, and after the commit the buffer is empty.
- R8: While programming, a read returns bit 7 as the complement of bit 7 of the last loaded byte and bit 6 as a toggle, with bits 5:0 zero. The toggle starts at 0 and flips after each read ends. After programming, reads return stored data.
- R9: A write strobe that ends before PUW_CYC cycles have passed since reset is ignored.
- R10: Reset clears the storage array to zero and leaves the bus undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, also marks power-up |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 15 | Byte address: row in [14:7], offset in [6:0] |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or end-of-write status |
| dout_en | output | 1 | High when the block drives the data bus |

## Verification
The assertions take for granted that the strobes, address and data are already synchronous to `clk`. They also assume that address and data are held steady for the whole low phase of a write strobe, since the last sampled cycle is the one kept. The stimulus changes every input only on the falling clock edge. It holds address and data constant across each strobe and keeps random gaps between bytes well inside the load window, except where a directed case spaces them wider on purpose. Random strobe widths start at GLITCH_CYC cycles, and the shorter and inhibited strobes are applied only in directed cases.

// File: rtl/pee_pkg.sv
package pee_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;
endpackage

// File: rtl/pee_mode_decode.sv
module pee_mode_decode (
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_sel,
    output logic wr_sel
);
    // read: select and output enable active, strobe idle
    assign rd_sel = ~ce_n & ~oe_n & we_n;
    // write: output enable must be idle, otherwise inhibited
    assign wr_sel = ~ce_n & oe_n & ~we_n;
endmodule

// File: rtl/pee_strobe_filter.sv
module pee_strobe_filter #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int GLITCH_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              start,
    output logic              done_ok,
    output logic              done_short,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_data
);
    localparam int CNT_W = $clog2(GLITCH_CYC + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(GLITCH_CYC);

    typedef struct packed {
        logic              sel;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
    } flt_t;

    flt_t s_d, s_q;
    logic ending;

    always_comb begin
        s_d     = s_q;
        s_d.sel = wr_sel;
        if (wr_sel) begin
            s_d.a = addr;
            s_d.d = din;
            if (!s_q.sel)
                s_d.cnt = CNT_W'(1);
            else if (s_q.cnt < LIM)
                s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ending     = s_q.sel & ~wr_sel;
    assign start      = wr_sel & ~s_q.sel;
    assign done_ok    = ending & (s_q.cnt >= LIM);
    assign done_short = ending & (s_q.cnt < LIM);
    assign lat_addr   = s_q.a;
    assign lat_data   = s_q.d;

    // R3: a strobe end is either accepted or rejected, never both, never with a start
    a_r3_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start, done_ok, done_short}));
    // R2: an end is only reported right after a sampled strobe cycle
    a_r2_end_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok || done_short) |-> $past(wr_sel));
endmodule

// File: rtl/pee_page_buffer.sv
module pee_page_buffer #(
    parameter int PAGE_W = 7,
    parameter int DATA_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load,
    input  logic [PAGE_W-1:0]                  idx,
    input  logic [DATA_W-1:0]                  data,
    input  logic                               clr,
    output logic [2**PAGE_W-1:0][DATA_W-1:0]   bytes,
    output logic [2**PAGE_W-1:0]               valid
);
    localparam int NB = 2**PAGE_W;

    typedef struct packed {
        logic [NB-1:0][DATA_W-1:0] b;
        logic [NB-1:0]             v;
    } pbuf_t;

    pbuf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.v = '0;
        end else if (load) begin
            s_d.b[idx] = data;
            s_d.v[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bytes = s_q.b;
    assign valid = s_q.v;

    // R7: a commit leaves the buffer empty
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (valid == '0));
    // R4: a loaded offset is marked and holds the loaded byte
    a_r4_load_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (valid[$past(idx)] && bytes[$past(idx)] == $past(data)));
endmodule

// File: rtl/pee_page_writer.sv
module pee_page_writer #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int PAGE_W     = 7,
    parameter int ROW_W      = 2,
    parameter int GLITCH_CYC = 3,
    parameter int LOAD_CYC   = 40,
    parameter int PROG_CYC   = 80,
    parameter int PUW_CYC    = 50,
    parameter int PUR_CYC    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    import pee_pkg::*;

    localparam int NB     = 2**PAGE_W;
    localparam int RB     = ADDR_W - PAGE_W;
    localparam int NG     = RB / ROW_W;
    localparam int MEM_W  = ROW_W + PAGE_W;
    localparam int MEM_N  = 2**MEM_W;
    localparam int LW     = $clog2(LOAD_CYC + 1);
    localparam int PW     = $clog2(PROG_CYC + 1);
    localparam int PU_MAX = (PUW_CYC > PUR_CYC) ? PUW_CYC : PUR_CYC;
    localparam int UW     = $clog2(PU_MAX + 1);
    localparam logic [LW-1:0] LOAD_T = LW'(LOAD_CYC);
    localparam logic [PW-1:0] PROG_T = PW'(PROG_CYC);
    localparam logic [UW-1:0] PUW_T  = UW'(PUW_CYC);
    localparam logic [UW-1:0] PUR_T  = UW'(PUR_CYC);
    localparam logic [UW-1:0] PUM_T  = UW'(PU_MAX);

    typedef struct packed {
        phase_e            phase;
        logic              run;
        logic [LW-1:0]     lcnt;
        logic [PW-1:0]     pcnt;
        logic [UW-1:0]     pu;
        logic [ROW_W-1:0]  row;
        logic [DATA_W-1:0] last;
        logic              tog;
        logic              rd_prev;
    } seq_t;

    seq_t s_d, s_q;

    logic rd_sel, wr_sel, start, done_ok, done_short;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic [NB-1:0][DATA_W-1:0] bytes;
    logic [NB-1:0] valid;
    logic wr_ok, rd_ok, accept, commit;
    logic [DATA_W-1:0] mem_q [MEM_N];

    function automatic logic [ROW_W-1:0] fold_row(input logic [ADDR_W-1:0] a);
        logic [ROW_W-1:0] f;
        f = '0;
        for (int g = 0; g < NG; g++)
            f = f ^ a[PAGE_W + g*ROW_W +: ROW_W];
        return f;
    endfunction

    pee_mode_decode u_dec (
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rd_sel(rd_sel), .wr_sel(wr_sel)
    );

    pee_strobe_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC)) u_flt (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .addr(addr), .din(din),
        .start(start), .done_ok(done_ok), .done_short(done_short),
        .lat_addr(lat_addr), .lat_data(lat_data)
    );

    pee_page_buffer #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .load(accept), .idx(lat_addr[PAGE_W-1:0]),
        .data(lat_data), .clr(commit), .bytes(bytes), .valid(valid)
    );

    assign wr_ok  = (s_q.pu >= PUW_T);
    assign rd_ok  = (s_q.pu >= PUR_T);
    assign accept = done_ok & wr_ok & (s_q.phase != PH_PROG);
    assign commit = (s_q.phase == PH_LOAD) & s_q.run & (s_q.lcnt == LW'(1))
                    & ~accept & ~start;

    always_comb begin
        s_d         = s_q;
        s_d.rd_prev = rd_sel;
        if (s_q.pu < PUM_T) s_d.pu = s_q.pu + UW'(1);
        if (accept) begin
            s_d.phase = PH_LOAD;
            s_d.run   = 1'b1;
            s_d.lcnt  = LOAD_T;
            s_d.row   = fold_row(lat_addr);
            s_d.last  = lat_data;
        end else begin
            case (s_q.phase)
                PH_LOAD: begin
                    if (start) begin
                        s_d.run = 1'b0;
                    end else if (done_short) begin
                        s_d.run  = 1'b1;
                        s_d.lcnt = LOAD_T;
                    end else if (commit) begin
                        s_d.phase = PH_PROG;
                        s_d.run   = 1'b0;
                        s_d.pcnt  = PROG_T;
                        s_d.tog   = 1'b0;
                    end else if (s_q.run) begin
                        s_d.lcnt = s_q.lcnt - LW'(1);
                    end
                end
                PH_PROG: begin
                    if (s_q.pcnt == PW'(1)) s_d.phase = PH_IDLE;
                    else                    s_d.pcnt  = s_q.pcnt - PW'(1);
                    if (s_q.rd_prev && !rd_sel) s_d.tog = ~s_q.tog;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_N; i++) mem_q[i] <= '0;
        end else if (commit) begin
            for (int b = 0; b < NB; b++)
                if (valid[b]) mem_q[{s_q.row, b[PAGE_W-1:0]}] <= bytes[b];
        end
    end

    assign dout_en = rd_sel & rd_ok;
    assign dout    = (s_q.phase == PH_PROG)
                   ? {~s_q.last[DATA_W-1], s_q.tog, {(DATA_W-2){1'b0}}}
                   : mem_q[{fold_row(addr), addr[PAGE_W-1:0]}];

    // R1: the bus is driven only in read mode
    a_r1_drive_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!ce_n && !oe_n && we_n));
    // R9: no page loading while writes are locked out
    a_r9_lockout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |-> (s_q.phase == PH_IDLE && valid == '0));
    // R7: the program cycle runs its full length
    a_r7_prog_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_PROG && s_q.pcnt != PW'(1)) |=> (s_q.phase == PH_PROG));
    // R7: strobes during programming leave the buffer empty
    a_r7_no_load_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_PROG && $past(s_q.phase) == PH_PROG) |-> (valid == '0));
    // R5: a stopped timer never leads straight into programming
    a_r5_stopped_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_LOAD && !s_q.run) |=> (s_q.phase != PH_PROG));
endmodule

// File: tb/test_pee_page_writer.sv
module test_pee_page_writer;
    localparam int L  = 40;
    localparam int P  = 80;
    localparam int G  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] refm [512];
    logic [7:0] pd [128];
    bit         pv [128];

    pee_page_writer i_pee_page_writer (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #4 clk = ~clk;

    function automatic int slot(input logic [14:0] a);
        logic [1:0] f;
        f = a[8:7] ^ a[10:9] ^ a[12:11] ^ a[14:13];
        return int'({f, a[6:0]});
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [14:0] a, input logic [7:0] d, input int width);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        repeat (width) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic rd_byte(input logic [14:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        d = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd_check(input string req, input logic [14:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic en;
        rd_byte(a, d, en);
        check(req, {23'd0, en, d}, {23'd0, 1'b1, exp});
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d, last;
        logic en;
        logic [14:0] a, lasta;
        int seed;
        seed = $urandom(32'd9071);
        for (int i = 0; i < 512; i++) refm[i] = 8'h00;

        // R10: reset leaves bus undriven
        wait_cyc(5);
        ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        check("R10 bus idle in reset", {31'd0, dout_en}, 32'd0);
        ce_n = 1'b1; oe_n = 1'b1;
        rst_n = 1'b1;
        // R1: read before power-up read delay is not driven
        rd_byte(15'h0005, d, en);
        check("R1 early read undriven", {31'd0, en}, 32'd0);
        wait_cyc(22);
        rd_check("R10 array cleared", 15'h0005, 8'h00);
        // R9: write during lockout
        wr_byte(15'h0005, 8'hA5, 4);
        wait_cyc(L + P + 20);
        rd_check("R9 lockout write ignored", 15'h0005, 8'h00);

        // R3: short strobe ignored
        wr_byte(15'h0123, 8'h3C, G - 1);
        wait_cyc(L + 10);
        rd_check("R3 short strobe ignored", 15'h0123, 8'h00);
        // R3 boundary width, R5 timing, R8 status
        wr_byte(15'h0123, 8'h3C, G);
        wait_cyc(L - 10);
        rd_check("R5 no commit before window", 15'h0123, 8'h00);
        wait_cyc(12);
        rd_check("R8 status first read", 15'h0123, 8'h80);
        rd_check("R8 status toggled", 15'h0700, 8'hC0);
        rd_check("R8 status toggles back", 15'h0123, 8'h80);
        wait_cyc(P + 10);
        refm[slot(15'h0123)] = 8'h3C;
        rd_check("R3 boundary strobe accepted", 15'h0123, 8'h3C);

        // R2: inhibit (output enable low while strobe low)
        @(negedge clk);
        addr = 15'h0123; din = 8'hFF; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        check("R1 no drive when inhibited", {31'd0, dout_en}, 32'd0);
        wait_cyc(5);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        wait_cyc(L + P + 10);
        rd_check("R2 inhibited write ignored", 15'h0123, 8'h3C);
        // R1: standby
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        check("R1 standby undriven", {31'd0, dout_en}, 32'd0);
        oe_n = 1'b1;

        // R5/R6/R4: restart across bytes, last row wins, overwrite
        wr_byte({8'h01, 7'd5}, 8'h11, G);
        wait_cyc(L - 10);
        wr_byte({8'h02, 7'd6}, 8'h22, G + 1);
        wait_cyc(L - 10);
        wr_byte({8'h02, 7'd5}, 8'h55, G + 2);
        wait_cyc(L + P + 10);
        refm[slot({8'h02, 7'd5})] = 8'h55;
        refm[slot({8'h02, 7'd6})] = 8'h22;
        rd_check("R4 overwrite same offset", {8'h02, 7'd5}, 8'h55);
        rd_check("R6 last row selects page", {8'h02, 7'd6}, 8'h22);
        rd_check("R6 first row untouched", {8'h01, 7'd5}, refm[slot({8'h01, 7'd5})]);
        // R5: gap longer than window splits commits
        wr_byte({8'h01, 7'd9}, 8'h99, G);
        wait_cyc(L + P + 10);
        wr_byte({8'h02, 7'd9}, 8'h66, G);
        wait_cyc(L + P + 10);
        refm[slot({8'h01, 7'd9})] = 8'h99;
        refm[slot({8'h02, 7'd9})] = 8'h66;
        rd_check("R5 separate commit first", {8'h01, 7'd9}, 8'h99);
        rd_check("R5 separate commit second", {8'h02, 7'd9}, 8'h66);

        // random pages
        for (int p = 0; p < 6; p++) begin
            int n;
            n = (p == 0) ? 128 : 1 + int'($urandom % 12);
            for (int k = 0; k < 128; k++) pv[k] = 1'b0;
            for (int k = 0; k < n; k++) begin
                a = (p == 0) ? {8'($urandom), 7'(k)} : 15'($urandom);
                d = 8'($urandom);
                wr_byte(a, d, G + int'($urandom % 4));
                pv[a[6:0]] = 1'b1; pd[a[6:0]] = d;
                lasta = a; last = d;
                wait_cyc(int'($urandom % (L - 15)));
            end
            wait_cyc(L + 4);
            rd_check("R8 status bit7", 15'($urandom), {~last[7], 7'd0});
            rd_check("R8 status bit6", 15'($urandom), {~last[7], 1'b1, 6'd0});
            // R7: strobe during programming
            a = 15'($urandom);
            wr_byte(a, ~refm[slot(a)], G + 1);
            wait_cyc(P + 10);
            for (int k = 0; k < 128; k++)
                if (pv[k]) refm[slot({lasta[14:7], 7'(k)})] = pd[k];
            rd_check("R7 strobe in program ignored", a, refm[slot(a)]);
            for (int k = 0; k < 128; k++)
                rd_check("R6 page contents", {lasta[14:7], 7'(k)},
                         refm[slot({lasta[14:7], 7'(k)})]);
        end
        finish_run();
    end
endmodule